// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory. It watches the select, address and write request of a left and a right port. When both ports are selected on the same address, it lets one of them go on and raises a low-active busy flag toward the other. The stalled port's write is held back inside the block until the collision ends. Arrival order is judged per clock cycle: the port whose select or address changed more recently is the newcomer and is the one that waits. A tie goes to the left port. After the collision ends, the loser's busy stays low for one extra cycle before the write is let through. This margin stands for the hold time a real write pulse needs after busy.

A mode input turns the block into a follower for arrays built wider from several memories. In that mode local arbitration is off and both busy outputs stay released. Each port's busy input pin then acts purely as a write blocker, driven by one master arbiter. Because only one decision exists for the whole array, no two chips can stall opposite ports and lock out both sides. A sticky collision flag records any arbitration event so that software can handle it as an interrupt.

Top module: `dpa_collide_arb`

## Requirements
- R1: In arbiter mode (`mode_slave`=0), both busy outputs stay high whenever the two addresses differ or either select is low.
- R2: A collision is a cycle in which both selects are high on equal addresses. When it is detected at a clock edge, busy goes low from that edge on for the port that is the newcomer at that edge. A port is the newcomer if its select rose, or its address changed while selected, compared with the previous edge.
- R3: If both ports are newcomers at the edge where the collision is first seen, or neither is, the left port wins and the right busy goes low.
- R4: `l_busy_n` and `r_busy_n` are never low in the same cycle.
- R5: In arbiter mode, a port's write strobe `x_wr_go` is 0 while that port's busy output is low, whatever level its busy input pin has. Otherwise `x_wr_go` = select AND write request.
- R6: A collision ends when the collision condition is false at an edge. The loser's busy then stays low for one more cycle and goes high at the following edge, and only from then on is its write passed.
- R7: In follower mode (`mode_slave`=1), both busy outputs are high and `x_wr_go` = select AND write request AND `x_busy_in_n`. A busy input tied low blocks every write of that port.
- R8: `coll_flag` goes to 1 at the edge after any cycle in which the arbiter holds a port busy. It stays 1 until an edge with `flag_clr`=1 at which no port is held busy, and a new busy wins over a clear in the same cycle.
- R9: Synchronous active-high reset releases both busy outputs, clears `coll_flag` and forgets all arrival history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_slave | input | 1 | 1 = follower mode, busy pins act only as write blockers |
| flag_clr | input | 1 | Clears the sticky collision flag |
| l_sel | input | 1 | Left port select, active high |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| l_busy_in_n | input | 1 | Left busy pin from a master, low blocks writes in follower mode |
| r_sel | input | 1 | Right port select, active high |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| r_busy_in_n | input | 1 | Right busy pin from a master, low blocks writes in follower mode |
| l_busy_n | output | 1 | Left busy, low = left port must stall |
| r_busy_n | output | 1 | Right busy, low = right port must stall |
| l_wr_go | output | 1 | Gated write strobe to the memory, left port |
| r_wr_go | output | 1 | Gated write strobe to the memory, right port |
| coll_flag | output | 1 | Sticky collision indicator |

## Verification
A stale arrival record or a wrong arbiter state shows up at the busy pins in the cycle after the deciding edge. The wrong port stalls, both ports stall, or a collision goes unflagged. The write strobes are combinational from that state, so a gating error shows as a passed or blocked write in the same cycle. A wrong hold length shows as a busy release one cycle early or late. The flag lags the busy state by one edge, so a broken set or clear priority shows one cycle after the busy change.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE  = 3'd0,
        ARB_LWAIT = 3'd1,
        ARB_LHOLD = 3'd2,
        ARB_RWAIT = 3'd3,
        ARB_RHOLD = 3'd4
    } arb_state_t;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_t;

    typedef struct packed {
        logic sel;
        logic wr;
        logic pin_busy_n;
    } port_ctl_t;

    localparam int NUM_PORTS = 2;

    // The newcomer loses; ties go against the right side.
    function automatic side_t pick_loser(input logic new_l, input logic new_r);
        if (new_l && !new_r) return SIDE_LEFT;
        return SIDE_RIGHT;
    endfunction

endpackage

// File: rtl/dpa_arrival.sv
module dpa_arrival #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);
    logic              sel_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            sel_q  <= sel;
            addr_q <= addr;
        end
    end

    assign fresh = sel && (!sel_q || (addr != addr_q));
endmodule

// File: rtl/dpa_arb_core.sv
module dpa_arb_core
    import dpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic follow,
    input  logic hit,
    input  logic new_l,
    input  logic new_r,
    output logic hold_l,
    output logic hold_r
);
    arb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (hit) begin
                    if (pick_loser(new_l, new_r) == SIDE_LEFT) state_d = ARB_LWAIT;
                    else                                       state_d = ARB_RWAIT;
                end
            end
            ARB_LWAIT: if (!hit) state_d = ARB_LHOLD;
            ARB_RWAIT: if (!hit) state_d = ARB_RHOLD;
            ARB_LHOLD: state_d = ARB_IDLE;
            ARB_RHOLD: state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
        if (follow) state_d = ARB_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_IDLE;
        else     state_q <= state_d;
    end

    assign hold_l = (state_q == ARB_LWAIT) || (state_q == ARB_LHOLD);
    assign hold_r = (state_q == ARB_RWAIT) || (state_q == ARB_RHOLD);
endmodule

// File: rtl/dpa_wr_gate.sv
module dpa_wr_gate
    import dpa_pkg::*;
(
    input  logic      follow,
    input  port_ctl_t ctl,
    input  logic      arb_hold,
    output logic      busy_n,
    output logic      wr_go
);
    logic blocked;

    always_comb begin
        if (follow) blocked = !ctl.pin_busy_n;
        else        blocked = arb_hold;
        busy_n = follow || !arb_hold;
        wr_go  = ctl.sel && ctl.wr && !blocked;
    end
endmodule

// File: rtl/dpa_collide_arb.sv
module dpa_collide_arb
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_slave,
    input  logic              flag_clr,
    input  logic              l_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              l_busy_in_n,
    input  logic              r_sel,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_go,
    output logic              r_wr_go,
    output logic              coll_flag
);
    port_ctl_t         ctl_v   [NUM_PORTS];
    logic [ADDR_W-1:0] addr_v  [NUM_PORTS];
    logic [NUM_PORTS-1:0] fresh_v, hold_v, busy_v, go_v;
    logic hit, flag_q;

    assign ctl_v[0]  = '{sel: l_sel, wr: l_wr, pin_busy_n: l_busy_in_n};
    assign ctl_v[1]  = '{sel: r_sel, wr: r_wr, pin_busy_n: r_busy_in_n};
    assign addr_v[0] = l_addr;
    assign addr_v[1] = r_addr;

    assign hit = l_sel && r_sel && (l_addr == r_addr);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpa_arrival #(.ADDR_W(ADDR_W)) u_arr (
            .clk   (clk),
            .rst   (rst),
            .sel   (ctl_v[p].sel),
            .addr  (addr_v[p]),
            .fresh (fresh_v[p])
        );
        dpa_wr_gate u_gate (
            .follow   (mode_slave),
            .ctl      (ctl_v[p]),
            .arb_hold (hold_v[p]),
            .busy_n   (busy_v[p]),
            .wr_go    (go_v[p])
        );
    end

    dpa_arb_core u_core (
        .clk    (clk),
        .rst    (rst),
        .follow (mode_slave),
        .hit    (hit),
        .new_l  (fresh_v[0]),
        .new_r  (fresh_v[1]),
        .hold_l (hold_v[0]),
        .hold_r (hold_v[1])
    );

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= (flag_q && !flag_clr) || (|hold_v);
    end

    assign l_busy_n  = busy_v[0];
    assign r_busy_n  = busy_v[1];
    assign l_wr_go   = go_v[0];
    assign r_wr_go   = go_v[1];
    assign coll_flag = flag_q;
endmodule

// File: rtl/dpa_collide_arb_chk.sv
module dpa_collide_arb_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_slave,
    input logic              l_sel,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_in_n,
    input logic              r_sel,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_go,
    input logic              r_wr_go,
    input logic              coll_flag
);
    logic same_spot;
    assign same_spot = l_sel && r_sel && (l_addr == r_addr);

    a_r4_never_both_busy: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_n && !r_busy_n));

    a_r5_left_busy_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (!mode_slave && !l_busy_n) |-> !l_wr_go);

    a_r5_right_busy_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (!mode_slave && !r_busy_n) |-> !r_wr_go);

    a_r7_follower_releases_busy: assert property (@(posedge clk) disable iff (rst)
        mode_slave |-> (l_busy_n && r_busy_n));

    a_r7_left_pin_blocks: assert property (@(posedge clk) disable iff (rst)
        (mode_slave && !l_busy_in_n) |-> !l_wr_go);

    a_r7_right_pin_blocks: assert property (@(posedge clk) disable iff (rst)
        (mode_slave && !r_busy_in_n) |-> !r_wr_go);

    a_r2_left_busy_needs_collision: assert property (@(posedge clk) disable iff (rst)
        $fell(l_busy_n) |-> $past(same_spot));

    a_r2_right_busy_needs_collision: assert property (@(posedge clk) disable iff (rst)
        $fell(r_busy_n) |-> $past(same_spot));

    a_r8_flag_follows_busy: assert property (@(posedge clk) disable iff (rst)
        (!l_busy_n || !r_busy_n) |=> coll_flag);
endmodule

bind dpa_collide_arb dpa_collide_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_slave  (mode_slave),
    .l_sel       (l_sel),
    .l_addr      (l_addr),
    .l_busy_in_n (l_busy_in_n),
    .r_sel       (r_sel),
    .r_addr      (r_addr),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_wr_go     (l_wr_go),
    .r_wr_go     (r_wr_go),
    .coll_flag   (coll_flag)
);

// File: tb/dpa_collide_arb_bench.sv
module dpa_collide_arb_bench;
    localparam int AW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_slave = 1'b0, flag_clr = 1'b0;
    logic l_sel = 1'b0, l_wr = 1'b0, l_bin_n = 1'b1;
    logic r_sel = 1'b0, r_wr = 1'b0, r_bin_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_busy_n, r_busy_n, l_wr_go, r_wr_go, coll_flag;

    int n_cmp = 0, n_bad = 0, cycles = 0;

    // Reference model: loser 0 none, 1 left, 2 right; lingering = extra cycle
    int m_loser = 0;
    bit m_linger = 0, m_flag = 0;
    bit m_psel_l = 0, m_psel_r = 0;
    logic [AW-1:0] m_paddr_l = '0, m_paddr_r = '0;

    always #10 clk = ~clk;

    dpa_collide_arb #(.ADDR_W(AW)) u_dpa_collide_arb (
        .clk(clk), .rst(rst), .mode_slave(mode_slave), .flag_clr(flag_clr),
        .l_sel(l_sel), .l_addr(l_addr), .l_wr(l_wr), .l_busy_in_n(l_bin_n),
        .r_sel(r_sel), .r_addr(r_addr), .r_wr(r_wr), .r_busy_in_n(r_bin_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_go(l_wr_go), .r_wr_go(r_wr_go), .coll_flag(coll_flag)
    );

    always @(posedge clk) begin
        bit newl, newr, collide;
        cycles++;
        if (rst) begin
            m_loser = 0; m_linger = 0; m_flag = 0;
            m_psel_l = 0; m_psel_r = 0; m_paddr_l = '0; m_paddr_r = '0;
        end else begin
            newl = l_sel && (!m_psel_l || l_addr != m_paddr_l);
            newr = r_sel && (!m_psel_r || r_addr != m_paddr_r);
            collide = l_sel && r_sel && (l_addr == r_addr);
            m_flag = (m_flag && !flag_clr) || (m_loser != 0);
            if (mode_slave) begin
                m_loser = 0; m_linger = 0;
            end else if (m_loser == 0) begin
                if (collide) m_loser = (newl && !newr) ? 1 : 2;
            end else if (!m_linger) begin
                if (!collide) m_linger = 1;
            end else begin
                m_loser = 0; m_linger = 0;
            end
            m_psel_l = l_sel; m_psel_r = r_sel;
            m_paddr_l = l_addr; m_paddr_r = r_addr;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic compare_model();
        bit eb_l, eb_r, eg_l, eg_r;
        eb_l = mode_slave || (m_loser != 1);
        eb_r = mode_slave || (m_loser != 2);
        eg_l = l_sel && l_wr && (mode_slave ? l_bin_n : eb_l);
        eg_r = r_sel && r_wr && (mode_slave ? r_bin_n : eb_r);
        check("R2", l_busy_n, eb_l, "model l_busy_n");
        check("R2", r_busy_n, eb_r, "model r_busy_n");
        check("R5", l_wr_go, eg_l, "model l_wr_go");
        check("R5", r_wr_go, eg_r, "model r_wr_go");
        check("R8", coll_flag, m_flag, "model coll_flag");
        check("R4", !(!l_busy_n && !r_busy_n), 1'b1, "not both busy");
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic drive(input bit ls, input int la, input bit lw,
                         input bit rs, input int ra, input bit rw);
        l_sel = ls; l_addr = AW'(la); l_wr = lw;
        r_sel = rs; r_addr = AW'(ra); r_wr = rw;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        @(posedge clk);
        while (cycles < 200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        tick(); tick();
        check("R9", l_busy_n, 1'b1, "reset l_busy_n");
        check("R9", r_busy_n, 1'b1, "reset r_busy_n");
        check("R9", coll_flag, 1'b0, "reset coll_flag");
        rst = 1'b0;

        // R1: different addresses, no busy
        drive(1, 5, 1, 1, 6, 1); tick(); tick();
        check("R1", l_busy_n, 1'b1, "differ l_busy_n");
        check("R1", r_busy_n, 1'b1, "differ r_busy_n");
        check("R1", r_wr_go, 1'b1, "differ r_wr_go");

        // R2/R5: left settled, right arrives later on the same address
        drive(1, 5, 0, 0, 6, 0); tick();
        drive(1, 5, 0, 1, 5, 1); tick();
        check("R2", r_busy_n, 1'b0, "late right busy");
        check("R2", l_busy_n, 1'b1, "early left free");
        check("R5", r_wr_go, 1'b0, "right write blocked");
        tick();
        check("R8", coll_flag, 1'b1, "flag set");

        // R6: left leaves, one linger cycle, then release
        drive(0, 5, 0, 1, 5, 1); tick();
        check("R6", r_busy_n, 1'b0, "linger busy");
        check("R6", r_wr_go, 1'b0, "linger write blocked");
        tick();
        check("R6", r_busy_n, 1'b1, "released");
        check("R6", r_wr_go, 1'b1, "write passes after release");

        // R8: clear when nothing busy
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        check("R8", coll_flag, 1'b0, "flag cleared");

        // R3: simultaneous arrival, left wins
        drive(0, 0, 0, 0, 0, 0); tick();
        drive(1, 9, 1, 1, 9, 1); tick();
        check("R3", r_busy_n, 1'b0, "tie right busy");
        check("R3", l_busy_n, 1'b1, "tie left free");
        check("R3", l_wr_go, 1'b1, "tie left writes");

        // R2/R5: right first, left later; winner pin low is ignored
        drive(0, 0, 0, 0, 0, 0); tick(); tick(); tick();
        drive(0, 3, 0, 1, 3, 1); r_bin_n = 1'b0; tick();
        drive(1, 3, 1, 1, 3, 1); tick();
        check("R2", l_busy_n, 1'b0, "late left busy");
        check("R5", l_wr_go, 1'b0, "left write blocked");
        check("R5", r_wr_go, 1'b1, "winner pin ignored");

        // R7: follower mode
        drive(0, 0, 0, 0, 0, 0); r_bin_n = 1'b1; tick(); tick(); tick();
        mode_slave = 1'b1; l_bin_n = 1'b0;
        drive(1, 3, 1, 1, 3, 1); tick(); tick();
        check("R7", l_busy_n, 1'b1, "follower l_busy_n");
        check("R7", r_busy_n, 1'b1, "follower r_busy_n");
        check("R7", l_wr_go, 1'b0, "pin low blocks left");
        check("R7", r_wr_go, 1'b1, "pin high passes right");
        mode_slave = 1'b0; l_bin_n = 1'b1;
        drive(0, 0, 0, 0, 0, 0); tick(); tick(); tick();

        // random walk over a small address window
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(3) == 0) l_sel = ~l_sel;
            if ($urandom_range(3) == 0) r_sel = ~r_sel;
            if ($urandom_range(4) == 0) l_addr = AW'($urandom_range(3));
            if ($urandom_range(4) == 0) r_addr = AW'($urandom_range(3));
            l_wr = 1'($urandom_range(1));
            r_wr = 1'($urandom_range(1));
            l_bin_n = 1'($urandom_range(1));
            r_bin_n = 1'($urandom_range(1));
            flag_clr = ($urandom_range(7) == 0);
            if ($urandom_range(63) == 0) mode_slave = ~mode_slave;
            tick();
        end
        finish_run();
    end
endmodule